// File: doc/BRIEF.md
# Rising-Edge Pulse Catcher

This block watches a level input and raises a sticky flag the first time that input goes from low to high. The flag stays up until a clear input is seen high at a clock edge. Everything runs on one system clock. The pulse input is first passed through a short chain of sampling registers. An edge tracker then turns the sampled level into a one-cycle rise indication. A two-state flag machine holds the result.

The rise indication comes from a remembered level, not from the raw input. Because of this, a pulse input that is still high when a clear arrives cannot set the flag again. The input has to fall and then rise once more. The flag follows the rule: next flag = forcing term OR (holding term AND present flag). The forcing term is "rise seen and clear low". The holding term is "clear low". This makes the clear input dominant.

The edge tracker has two states. LVL_LOW means the sampled input was last low; LVL_HIGH means it was last high. A rise is reported only in LVL_LOW when the sampled level is 1. The tracker moves to LVL_HIGH on a sampled 1 and back to LVL_LOW on a sampled 0.

The flag machine also has two states. FLAG_IDLE drives the output to 0 and FLAG_HELD drives it to 1. It has two transitions. "arm" goes from FLAG_IDLE to FLAG_HELD on a rise with clear low. "drop" goes from FLAG_HELD to FLAG_IDLE when clear is high. In every other case the state stays where it is.

Top module: `pulse_catcher`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, `catch_out` is 0 afterwards. This reset is synchronous and active low. It also clears the sampling registers and puts the edge tracker in LVL_LOW.
- R2: A 0-to-1 change of `pulse_in` set up before edge k makes `catch_out` 1 after edge k+SYNC_DEPTH. Before that edge, `catch_out` is still 0.
- R3: Once `catch_out` is 1, it stays 1 for as long as `clear_in` is 0, whatever `pulse_in` does.
- R4: `clear_in` = 1 at a rising edge makes `catch_out` 0 after that edge. `catch_out` stays 0 for as long as `clear_in` stays 1, even while `pulse_in` toggles.
- R5: If a detected rise and `clear_in` = 1 fall on the same edge, the clear wins and `catch_out` is 0.
- R6: If `pulse_in` stays high through a clear, `catch_out` stays 0 after `clear_in` returns to 0. It is set again only after `pulse_in` falls and then rises again.
- R7: `catch_out` goes from 0 to 1 only at an edge where a rise was detected. Any pattern of `pulse_in` without a 0-to-1 change leaves it at 0.
- R8: A high pulse on `pulse_in` lasting one clock period is caught. Each rise produces exactly one cycle of rise indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Level input watched for 0-to-1 changes |
| clear_in | input | 1 | Active-high clear of the caught flag, dominant |
| catch_out | output | 1 | Caught flag, 1 after a rise until cleared |

## Verification
A rise on `pulse_in` shows on `catch_out` SYNC_DEPTH+1 edges after the input changes. There is one edge for each sampling stage and one edge for the flag. A clear shows one edge after it is applied. Stimulus is driven on falling clock edges and outputs are read on falling clock edges, half a period away from the active edge. The directed cases wait exactly SYNC_DEPTH or SYNC_DEPTH+1 edges and check both sides of the set latency. Where a clear must meet a rise on the same edge, it is timed SYNC_DEPTH edges after the pulse change. In the random phase, a cycle-by-cycle bench model built from the requirements is stepped on the same edges, and the output is compared against it on every falling edge.

// File: rtl/pulse_catcher_pkg.sv
package pulse_catcher_pkg;

    // Remembered level of the sampled pulse input
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_state_t;

    // Caught-flag machine
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_t;

endpackage

// File: rtl/pc_sampler.sv
module pc_sampler #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic sampled_o
);

    localparam int LAST = DEPTH - 1;

    logic [LAST:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= level_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[LAST-1:0], level_i};
                end
            end
        end
    endgenerate

    assign sampled_o = stage_q[LAST];

endmodule

// File: rtl/pc_edge_fsm.sv
module pc_edge_fsm
    import pulse_catcher_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sampled_i,
    output logic rise_o
);

    level_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and rise output
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (sampled_i) begin
                    rise_o  = 1'b1;
                    state_d = LVL_HIGH;
                end
            end
            LVL_HIGH: begin
                if (!sampled_i) begin
                    state_d = LVL_LOW;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // R8: a rise lasts exactly one cycle
    p_rise_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("p_rise_one_cycle_r8");

    // R6: a level that stays high gives no second rise
    p_no_rise_when_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sampled_i |=> (sampled_i -> !rise_o))
        else $error("p_no_rise_when_held_r6");

endmodule

// File: rtl/pc_flag_fsm.sv
module pc_flag_fsm
    import pulse_catcher_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic clear_i,
    output logic flag_o
);

    flag_state_t state_q, state_d;

    // Next flag = forcing (rise, no clear) OR holding (no clear) AND flag
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (rise_i && !clear_i) begin
                    state_d = FLAG_HELD;      // arm
                end
            end
            FLAG_HELD: begin
                if (clear_i) begin
                    state_d = FLAG_IDLE;      // drop
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !flag_o)
        else $error("p_reset_clears_r1");

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !clear_i) |=> flag_o)
        else $error("p_rise_sets_r2");

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clear_i) |=> flag_o)
        else $error("p_hold_r3");

    // R4 and R5: clear dominates any rise on the same edge
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !flag_o)
        else $error("p_clear_wins_r4");

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !rise_i) |=> !flag_o)
        else $error("p_no_spurious_r7");

endmodule

// File: rtl/pulse_catcher.sv
module pulse_catcher #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic clear_in,
    output logic catch_out
);

    logic sampled;
    logic rise;

    pc_sampler #(
        .DEPTH (SYNC_DEPTH)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (pulse_in),
        .sampled_o (sampled)
    );

    pc_edge_fsm u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sampled_i (sampled),
        .rise_o    (rise)
    );

    pc_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .clear_i (clear_in),
        .flag_o  (catch_out)
    );

    // R7 at the ports: without a pulse change the flag cannot rise
    p_port_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!catch_out && !pulse_in && !sampled) |=> !catch_out)
        else $error("p_port_quiet_r7");

endmodule

// File: tb/pulse_catcher_tb_top.sv
module pulse_catcher_tb_top;

    localparam int SYNC_DEPTH = 2;
    localparam int RAND_CYCLES = 3000;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic clear_in = 1'b0;
    logic catch_out;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pulse_catcher #(
        .SYNC_DEPTH (SYNC_DEPTH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .clear_in  (clear_in),
        .catch_out (catch_out)
    );

    // Behavioural model from the requirements
    logic [SYNC_DEPTH-1:0] m_pipe = '0;
    logic m_last = 1'b0;
    logic m_flag = 1'b0;

    function automatic logic next_flag(logic flag, logic newest, logic last, logic clr);
        logic rose;
        rose = newest && !last;
        return !clr && (rose || flag);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe <= '0;
            m_last <= 1'b0;
            m_flag <= 1'b0;
        end else begin
            for (int i = SYNC_DEPTH - 1; i > 0; i--) begin
                m_pipe[i] <= m_pipe[i-1];
            end
            m_pipe[0] <= pulse_in;
            m_last <= m_pipe[SYNC_DEPTH-1];
            m_flag <= next_flag(m_flag, m_pipe[SYNC_DEPTH-1], m_last, clear_in);
        end
    end

    task automatic check(string req, logic actual, logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_fails++;
            $display("FAIL %s: catch_out=%0b expected=%0b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        check("R1", catch_out, 1'b0);
        rst_n = 1'b1;
        tick(2);
        check("R1", catch_out, 1'b0);

        // R2: set latency, exact edge
        pulse_in = 1'b1;
        tick(SYNC_DEPTH);
        check("R2", catch_out, 1'b0);
        tick(1);
        check("R2", catch_out, 1'b1);

        // R3: hold while pulse falls and toggles
        pulse_in = 1'b0;
        tick(4);
        check("R3", catch_out, 1'b1);
        pulse_in = 1'b1; tick(1); pulse_in = 1'b0; tick(SYNC_DEPTH + 2);
        check("R3", catch_out, 1'b1);

        // R4: clear
        clear_in = 1'b1;
        tick(1);
        check("R4", catch_out, 1'b0);
        pulse_in = 1'b1; tick(2); pulse_in = 1'b0; tick(SYNC_DEPTH + 2);
        check("R4", catch_out, 1'b0);
        clear_in = 1'b0;
        tick(3);
        check("R7", catch_out, 1'b0);

        // R5: clear on the same edge as the rise
        pulse_in = 1'b1;
        tick(SYNC_DEPTH);
        clear_in = 1'b1;
        tick(1);
        check("R5", catch_out, 1'b0);
        clear_in = 1'b0;

        // R6: pulse held high through the clear
        tick(4);
        check("R6", catch_out, 1'b0);
        pulse_in = 1'b0;
        tick(SYNC_DEPTH + 2);
        check("R6", catch_out, 1'b0);
        pulse_in = 1'b1;
        tick(SYNC_DEPTH + 1);
        check("R6", catch_out, 1'b1);

        // R8: single-cycle pulse
        clear_in = 1'b1; pulse_in = 1'b0;
        tick(SYNC_DEPTH + 2);
        clear_in = 1'b0;
        tick(1);
        check("R8", catch_out, 1'b0);
        pulse_in = 1'b1;
        tick(1);
        pulse_in = 1'b0;
        tick(SYNC_DEPTH);
        check("R8", catch_out, 1'b1);

        // R1: reset in the middle clears the flag
        rst_n = 1'b0;
        tick(1);
        check("R1", catch_out, 1'b0);
        rst_n = 1'b1;
        tick(SYNC_DEPTH + 2);
        check("R7", catch_out, 1'b0);

        // Random phase against the model (R2..R8)
        for (int c = 0; c < RAND_CYCLES; c++) begin
            check("R7", catch_out, m_flag);
            if (($urandom % 3) == 0) pulse_in = ~pulse_in;
            clear_in = (($urandom % 10) == 0);
            tick(1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule